// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product. An AND array forms every partial-product bit. The rows of full adders that sum those bits do not ripple a carry along a row. Each adder hands its carry to the row below, one column further left, so every row is only one full adder deep. A register bank follows every row. One ripple-carry adder at the end combines the leftover sum and carry vectors into the upper half of the product. The multiplicand and the multiplier bits that are still needed travel along the pipe beside the partial sums. The low product bits travel the same way once they are settled. Each stage therefore works only on data from one input pair.

Operands enter on a valid/ready stream and products leave on another. One pair is accepted on every rising edge where `in_valid` and `in_ready` are both high. A product is handed over on every edge where `out_valid` and `out_ready` are both high. Back-pressure is global. `in_ready` equals `!out_valid || out_ready`. While the output holds a product that the consumer refuses, every stage freezes and no new pair is taken. While the output register is empty, or its product is being taken, the whole pipe advances. The parameter N must be at least 3. The default is 4. Reset is synchronous and active high.

Top module: `csmul_pipe`

## Requirements
- R1: Every product delivered equals the unsigned product of the operand pair it belongs to, as a 2N-bit value with bit 0 as the least significant bit.
- R2: With `out_ready` held high, the product of a pair appears with `out_valid` high right after the (N+1)-th rising edge, counting the edge that accepted the pair as the first (5 edges for N=4).
- R3: Whenever `out_ready` is high, `in_ready` is high, so with the consumer always ready a new pair is accepted on every consecutive edge.
- R4: A synchronous reset empties the pipe. After it, `out_valid` is low, `in_ready` is high, and no pair accepted before the reset ever produces a result.
- R5: When `out_valid` is high and `out_ready` is low, on the next edge `out_valid` stays high and `out_product` keeps its value.
- R6: Edges where `in_valid` is low add no result: the number of products delivered equals the number of pairs accepted.
- R7: Products leave in the order their pairs were accepted, with none lost or repeated, also across stalls.
- R8: A pair offered while `in_ready` is low is not taken, and it produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is offered |
| in_ready | output | 1 | Block takes the offered pair on this edge |
| in_a | input | N | Multiplicand, unsigned |
| in_b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | `out_product` holds a result |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_product | output | 2N | Unsigned product |

## Verification
With the consumer ready, a result is due exactly N+1 rising edges after its pair is accepted, counting the accepting edge. Stalls stretch this by one edge for every edge where a result is held and refused. The bench drives inputs one time unit after a rising edge and reads outputs on the falling edge. The latency scenario counts edges from acceptance to the first falling edge that shows `out_valid`. Every other result is matched against a queue filled on the falling edge before each accepting edge, so the comparison does not depend on stall timing. A held result is compared with the value seen one falling edge earlier.

// File: rtl/csmul_pkg.sv
package csmul_pkg;

  // One-bit full adder: returns {carry, sum}.
  function automatic logic [1:0] fa(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

endpackage

// File: rtl/csmul_pp_row.sv
module csmul_pp_row #(
  parameter int N = 4
) (
  input  logic [N-1:0] mcand,
  input  logic         mbit,
  output logic [N-1:0] pp
);
  // Bit i of the row is multiplicand bit i AND the chosen multiplier bit.
  for (genvar i = 0; i < N; i++) begin : g_and
    assign pp[i] = mcand[i] & mbit;
  end
endmodule

// File: rtl/csmul_csa_row.sv
module csmul_csa_row #(
  parameter int N = 4
) (
  input  logic [N-1:0] pp,      // new partial-product row
  input  logic [N-2:0] sh_in,   // upper bits of the previous sum vector
  input  logic [N-1:0] c_in,    // carries from the previous row
  output logic [N-1:0] s_out,
  output logic [N-1:0] c_out
);
  import csmul_pkg::*;

  // Independent full adders: no carry moves sideways inside the row.
  for (genvar i = 0; i < N; i++) begin : g_col
    logic y;
    if (i < N-1) begin : g_mid
      assign y = sh_in[i];
    end else begin : g_top
      assign y = 1'b0;
    end
    assign {c_out[i], s_out[i]} = fa(pp[i], y, c_in[i]);
  end
endmodule

// File: rtl/csmul_rca.sv
module csmul_rca #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] sum
);
  import csmul_pkg::*;

  logic [N-1:0] cy;
  assign cy[0] = 1'b0;

  // The top bit needs no carry out: the product fits in 2N bits.
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < N-1) begin : g_chain
      assign {cy[i+1], sum[i]} = fa(x[i], y[i], cy[i]);
    end else begin : g_last
      assign sum[i] = x[i] ^ y[i] ^ cy[i];
    end
  end
endmodule

// File: rtl/csmul_pipe.sv
module csmul_pipe #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] out_product
);
  localparam int LAST = N - 1;

  // Global stall: every register moves only when the output can move.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage k holds the state after partial-product row k has been added.
  for (genvar k = 0; k < N; k++) begin : g_st
    logic         v_r,  v_n;
    logic [N-2:0] sh_r, sh_n;   // sum bits still unresolved
    logic [N-1:0] c_r,  c_n;    // carries heading to the next row
    logic [k:0]   lo_r, lo_n;   // settled low product bits
    logic [N-1:0] pp;

    if (k == 0) begin : g_src
      csmul_pp_row #(.N(N)) u_pp (.mcand(in_a), .mbit(in_b[0]), .pp(pp));
      assign v_n  = in_valid;
      assign sh_n = pp[N-1:1];
      assign c_n  = '0;
      assign lo_n = pp[0];
    end else begin : g_add
      logic [N-1:0] s_row;
      csmul_pp_row #(.N(N)) u_pp (
        .mcand (g_st[k-1].g_fwd.a_r),
        .mbit  (g_st[k-1].g_fwd.bh_r[0]),
        .pp    (pp)
      );
      csmul_csa_row #(.N(N)) u_csa (
        .pp    (pp),
        .sh_in (g_st[k-1].sh_r),
        .c_in  (g_st[k-1].c_r),
        .s_out (s_row),
        .c_out (c_n)
      );
      assign v_n  = g_st[k-1].v_r;
      assign sh_n = s_row[N-1:1];
      assign lo_n = {s_row[0], g_st[k-1].lo_r};
    end

    always_ff @(posedge clk) begin
      if (rst)      v_r <= 1'b0;
      else if (adv) v_r <= v_n;
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        sh_r <= sh_n;
        c_r  <= c_n;
        lo_r <= lo_n;
      end
    end

    // Operand bits still needed downstream ride along with the sums.
    if (k < LAST) begin : g_fwd
      logic [N-1:0]   a_r;
      logic [N-2-k:0] bh_r;     // multiplier bits k+1 .. N-1
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (adv) begin
            a_r  <= in_a;
            bh_r <= in_b[N-1:1];
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (adv) begin
            a_r  <= g_st[k-1].g_fwd.a_r;
            bh_r <= g_st[k-1].g_fwd.bh_r[N-1-k:1];
          end
        end
      end
    end
  end

  // Final carry-propagate step resolves the upper half.
  logic [N-1:0] hi;
  csmul_rca #(.N(N)) u_rca (
    .x   ({1'b0, g_st[LAST].sh_r}),
    .y   (g_st[LAST].c_r),
    .sum (hi)
  );

  always_ff @(posedge clk) begin
    if (rst)      out_valid <= 1'b0;
    else if (adv) out_valid <= g_st[LAST].v_r;
  end

  always_ff @(posedge clk) begin
    if (adv) out_product <= {hi, g_st[LAST].lo_r};
  end
endmodule

// File: rtl/csmul_pipe_chk.sv
module csmul_pipe_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   in_a,
  input logic [N-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*N-1:0] out_product
);
  localparam int LAT = N + 1;

  // Behavioural reference pipe driven only from the ports.
  logic [2*N-1:0] ref_p [LAT];
  logic [LAT-1:0] ref_v;
  logic           go;
  assign go = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_v <= '0;
    end else if (go) begin
      ref_v <= {ref_v[LAT-2:0], in_valid};
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      ref_p[0] <= (2*N)'(in_a) * (2*N)'(in_b);
      for (int s = 1; s < LAT; s++) ref_p[s] <= ref_p[s-1];
    end
  end

  // R1
  product_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_product == ref_p[LAT-1]);

  // R6
  valid_align_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == ref_v[LAT-1]);

  // R3
  ready_when_drained_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R4
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && in_ready);

  // R5
  hold_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_product));
endmodule

bind csmul_pipe csmul_pipe_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product)
);

// File: tb/csmul_pipe_bench.sv
`timescale 1ns/1ps
module csmul_pipe_bench;
  localparam int N   = 4;
  localparam int LAT = N + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N-1:0]   in_a = '0;
  logic [N-1:0]   in_b = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [2*N-1:0] out_product;

  int n_cmp = 0;
  int n_bad = 0;
  int n_acc = 0;
  int n_out = 0;
  int cyc   = 0;
  logic [2*N-1:0] expq[$];
  bit             stall_prev = 0;
  logic [2*N-1:0] held;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csmul_pipe #(.N(N)) u_csmul_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_product(out_product)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard on the falling edge: pop first, then record acceptance.
  always @(negedge clk) begin
    if (rst) begin
      stall_prev = 0;
    end else begin
      if (stall_prev) begin
        chk(out_valid == 1'b1, "R5 valid held", out_valid, 1);
        chk(out_product == held, "R5 product held", out_product, held);
      end
      if (out_valid && out_ready) begin
        n_out++;
        if (expq.size() == 0) begin
          chk(0, "R7 extra result", out_product, -1);
        end else begin
          logic [2*N-1:0] e;
          e = expq.pop_front();
          chk(out_product == e, "R1/R7 product", out_product, e);
        end
      end
      if (in_valid && in_ready) begin
        n_acc++;
        expq.push_back((2*N)'(in_a) * (2*N)'(in_b));
      end
      stall_prev = out_valid && !out_ready;
      held       = out_product;
    end
  end

  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b);
    bit taken = 0;
    in_a = a; in_b = b; in_valid = 1'b1;
    while (!taken) begin
      @(negedge clk);
      taken = in_ready;
      @(posedge clk); #1;
    end
  endtask

  task automatic drain();
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 40 && expq.size() != 0; i++) begin
      @(posedge clk); #1;
    end
    repeat (2) @(posedge clk); #1;
    chk(expq.size() == 0, "R7 all results delivered", expq.size(), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R4 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_latency();
    int cnt;
    out_ready = 1'b1;
    send(4'd13, 4'd11);
    in_valid = 1'b0;
    cnt = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid) break;
      @(posedge clk);
      cnt++;
    end
    chk(cnt == LAT, "R2 latency", cnt, LAT);
    chk(out_product == 8'd143, "R1 13x11", out_product, 143);
    drain();
  endtask

  task automatic t_exhaustive();
    int t0;
    out_ready = 1'b1;
    t0 = cyc;
    for (int i = 0; i < 256; i++) send(i[7:4], i[3:0]);
    chk(cyc - t0 == 256, "R3 one pair per edge", cyc - t0, 256);
    drain();
  endtask

  task automatic t_bubbles();
    int a0, o0;
    a0 = n_acc; o0 = n_out;
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 1) begin
        in_valid = 1'b0;
        in_a = 4'hF; in_b = 4'hF;
        @(posedge clk); #1;
      end else begin
        send(4'(i), 4'(i * 7));
      end
    end
    drain();
    chk(n_out - o0 == n_acc - a0, "R6 results equal accepted", n_out - o0, n_acc - a0);
    chk(n_acc - a0 == 27, "R6 accepted count", n_acc - a0, 27);
  endtask

  task automatic t_backpressure();
    fork
      begin
        for (int i = 0; i < 30; i++) send(4'(15 - i), 4'(i + 3));
        in_valid = 1'b0;
      end
      begin
        for (int i = 0; i < 90; i++) begin
          out_ready = (i % 5 < 2) ? 1'b0 : 1'b1;
          @(posedge clk); #1;
        end
      end
    join
    drain();
  endtask

  task automatic t_refused_offer();
    int a0, o0, guard;
    a0 = n_acc; o0 = n_out;
    out_ready = 1'b0;
    guard = 0;
    in_valid = 1'b1;
    while (guard < 20) begin
      in_a = 4'(guard + 1); in_b = 4'(9);
      @(negedge clk);
      if (!in_ready) break;
      @(posedge clk); #1;
      guard++;
    end
    // Offer new pairs while the pipe is blocked.
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      in_a = 4'hF; in_b = 4'(i + 12);
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 stays blocked", in_ready, 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(n_acc - a0 == LAT, "R8 accepted while blocked", n_acc - a0, LAT);
    drain();
    chk(n_out - o0 == LAT, "R8 refused pairs produce nothing", n_out - o0, LAT);
  endtask

  task automatic t_reset_midstream();
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) send(4'(i + 5), 4'(i + 6));
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    expq.delete();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 in-flight pairs discarded", out_valid, 0);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_exhaustive();
    t_bubbles();
    t_backpressure();
    t_refused_offer();
    t_reset_midstream();
    t_latency();
    finish_run();
  end
endmodule